// File: doc/BRIEF.md
# Triple-Redundant Voted Control State Machine

This block is a small start/stop control sequencer whose state register is held three times over. Every clock, a bitwise majority voter merges the three stored copies into one voted state. That voted value alone feeds the next-state decode and the status outputs. All three copies then load the same next state, so a copy hit by an upset is rewritten with the majority's value on the following edge. A registered mismatch flag reports that the copies disagreed, and the sequence carries on without a break.

The sequence has four named states. Idle (`PH_IDLE`) waits for a start request. Arm (`PH_ARM`) lasts one cycle. Run (`PH_RUN`) lasts `RUN_LEN` cycles, timed by a small counter. Done (`PH_DONE`) lasts one cycle and then returns to Idle.

The states use a distance-two code with even parity: Idle `3'b000`, Arm `3'b011`, Run `3'b101`, Done `3'b110`. Any odd-parity voted value is illegal and is decoded as a fall-back to Idle. For testing, a per-copy fault mask is XORed into the value each copy loads at a clock edge.

The transitions are as follows:
- IDLE→ARM on start.
- ARM→RUN when there is no stop.
- ARM→IDLE on stop.
- RUN→IDLE on stop.
- RUN→DONE after `RUN_LEN` cycles.
- DONE→IDLE always.
- Any illegal value→IDLE.

Top module: `tmr_ctrl_fsm`

## Requirements
- R1: A clock edge with `rst` high loads Idle (`3'b000`) into all three copies, whatever `fault_mask` holds. After reset, `state_o`=000, `busy`=0, `done`=0 and `mismatch`=0.
- R2: In Idle, a start request with `stop_req` low moves the machine to Arm (`3'b011`). From Arm it moves to Run (`3'b101`) on the next edge. `busy` is high in Arm and Run.
- R3: Run lasts exactly `RUN_LEN` cycles and is followed by one cycle of Done (`3'b110`), with `done`=1 and `busy`=0. Idle follows Done.
- R4: `stop_req` returns Arm or Run to Idle on the next edge. In Idle, `stop_req` takes priority over `start_req`. `start_req` has no effect outside Idle.
- R5: The voter is bitwise. Each bit of the voted state is the majority of that bit in the three copies, so one corrupted copy never changes the voted state or the sequence timing.
- R6: All three copies load the same next state, computed from the voted state. One edge with no fault mask leaves the three copies equal again (scrubbing).
- R7: `mismatch` is registered. It is high for the one cycle after any cycle in which a copy differs from the voted state, and low otherwise.
- R8: If the voted state is illegal (odd parity), the next edge loads Idle.
- R9: `fault_mask` bits [3i+2:3i] are XORed into the value copy i loads at that edge, with copy 0 in the low bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_req | input | 1 | Request to begin a sequence |
| stop_req | input | 1 | Request to abort back to Idle |
| fault_mask | input | 9 | Per-copy XOR mask applied at load (copy i at bits 3i+2:3i) |
| state_o | output | 3 | Voted state code |
| busy | output | 1 | High in Arm or Run |
| done | output | 1 | High for the single Done cycle |
| mismatch | output | 1 | Registered flag: the copies disagreed in the previous cycle |

## Verification
Every cycle, the assertions check four things:
- The copies reconverge after any edge with no fault mask.
- The mismatch flag follows the previous cycle's disagreement exactly.
- An illegal voted value is followed by Idle, and reset loads Idle.
- Done never lasts two cycles.

Only the bench's scenarios can show the rest:
- The exact Run length.
- That stop wins over start in Idle.
- That a corruption of any single copy, injected mid-sequence, leaves the Done cycle where it would have been.
- The path from a double-copy illegal corruption back to Idle.

// File: rtl/tmr_ctrl_pkg.sv
package tmr_ctrl_pkg;

    localparam int STATE_W = 3;
    localparam int NCOPY   = 3;

    // Distance-two, even-parity state code
    typedef enum logic [STATE_W-1:0] {
        PH_IDLE = 3'b000,
        PH_ARM  = 3'b011,
        PH_RUN  = 3'b101,
        PH_DONE = 3'b110
    } phase_t;

    function automatic logic code_legal(input logic [STATE_W-1:0] v);
        return ~(^v);
    endfunction

endpackage

// File: rtl/tmr_majority.sv
module tmr_majority #(
    parameter int W = 3
) (
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    input  logic [W-1:0] in_c,
    output logic [W-1:0] voted,
    output logic         disagree
);
    genvar gb;
    generate
        for (gb = 0; gb < W; gb++) begin : g_bit
            assign voted[gb] = (in_a[gb] & in_b[gb]) |
                               (in_a[gb] & in_c[gb]) |
                               (in_b[gb] & in_c[gb]);
        end
    endgenerate

    assign disagree = (in_a != voted) | (in_b != voted) | (in_c != voted);
endmodule

// File: rtl/tmr_state_copies.sv
module tmr_state_copies
    import tmr_ctrl_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [STATE_W-1:0]       next_state,
    input  logic [NCOPY*STATE_W-1:0] fault_mask,
    output logic [NCOPY*STATE_W-1:0] copies
);
    genvar gc;
    generate
        for (gc = 0; gc < NCOPY; gc++) begin : g_copy
            logic [STATE_W-1:0] reg_q;
            always_ff @(posedge clk) begin
                if (rst) reg_q <= PH_IDLE;
                else     reg_q <= next_state ^ fault_mask[gc*STATE_W +: STATE_W];
            end
            assign copies[gc*STATE_W +: STATE_W] = reg_q;
        end
    endgenerate
endmodule

// File: rtl/tmr_run_timer.sv
module tmr_run_timer
    import tmr_ctrl_pkg::*;
#(
    parameter int RUN_LEN = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [STATE_W-1:0] phase,
    output logic               run_last
);
    localparam int CW = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || phase != PH_RUN) cnt_q <= '0;
        else if (cnt_q != LAST)     cnt_q <= cnt_q + 1'b1;
    end

    assign run_last = (phase == PH_RUN) && (cnt_q == LAST);
endmodule

// File: rtl/tmr_next_phase.sv
module tmr_next_phase
    import tmr_ctrl_pkg::*;
(
    input  logic [STATE_W-1:0] voted,
    input  logic               start_req,
    input  logic               stop_req,
    input  logic               run_last,
    output logic [STATE_W-1:0] next_state
);
    always_comb begin
        unique case (voted)
            PH_IDLE: next_state = (start_req && !stop_req) ? PH_ARM : PH_IDLE;
            PH_ARM:  next_state = stop_req ? PH_IDLE : PH_RUN;
            PH_RUN: begin
                if (stop_req)      next_state = PH_IDLE;
                else if (run_last) next_state = PH_DONE;
                else               next_state = PH_RUN;
            end
            PH_DONE: next_state = PH_IDLE;
            default: next_state = PH_IDLE;   // illegal voted code: safe fall-back
        endcase
    end
endmodule

// File: rtl/tmr_ctrl_fsm.sv
module tmr_ctrl_fsm
    import tmr_ctrl_pkg::*;
#(
    parameter int RUN_LEN = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_req,
    input  logic       stop_req,
    input  logic [8:0] fault_mask,
    output logic [2:0] state_o,
    output logic       busy,
    output logic       done,
    output logic       mismatch
);
    logic [NCOPY*STATE_W-1:0] copies;
    logic [STATE_W-1:0]       voted;
    logic [STATE_W-1:0]       next_state;
    logic                     disagree;
    logic                     run_last;
    logic                     mismatch_q;

    tmr_state_copies u_copies (
        .clk        (clk),
        .rst        (rst),
        .next_state (next_state),
        .fault_mask (fault_mask),
        .copies     (copies)
    );

    tmr_majority #(.W(STATE_W)) u_vote (
        .in_a     (copies[0*STATE_W +: STATE_W]),
        .in_b     (copies[1*STATE_W +: STATE_W]),
        .in_c     (copies[2*STATE_W +: STATE_W]),
        .voted    (voted),
        .disagree (disagree)
    );

    tmr_run_timer #(.RUN_LEN(RUN_LEN)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .phase    (voted),
        .run_last (run_last)
    );

    tmr_next_phase u_next (
        .voted      (voted),
        .start_req  (start_req),
        .stop_req   (stop_req),
        .run_last   (run_last),
        .next_state (next_state)
    );

    // Registered disagreement flag
    always_ff @(posedge clk) begin
        if (rst) mismatch_q <= 1'b0;
        else     mismatch_q <= disagree;
    end

    // Output decode from the voted state
    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        unique case (voted)
            PH_ARM, PH_RUN: busy = 1'b1;
            PH_DONE:        done = 1'b1;
            default: ;
        endcase
    end

    assign state_o  = voted;
    assign mismatch = mismatch_q;

    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (voted == PH_IDLE && !disagree)); // R1
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R3
    AST_SCRUB_EQUAL: assert property (@(posedge clk) disable iff (rst)
        (fault_mask == '0) |=> (copies[2:0] == copies[5:3] && copies[5:3] == copies[8:6])); // R6
    AST_MISMATCH_SET: assert property (@(posedge clk) disable iff (rst) disagree |=> mismatch); // R7
    AST_MISMATCH_CLR: assert property (@(posedge clk) disable iff (rst) !disagree |=> !mismatch); // R7
    AST_ILLEGAL_SAFE: assert property (@(posedge clk) disable iff (rst)
        (!code_legal(voted) && fault_mask == '0) |=> (voted == PH_IDLE)); // R8
endmodule

// File: tb/tmr_ctrl_fsm_tb.sv
module tmr_ctrl_fsm_tb;
    localparam int RUN_LEN = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_req = 1'b0;
    logic       stop_req = 1'b0;
    logic [8:0] fault_mask = '0;
    logic [2:0] state_o;
    logic       busy, done, mismatch;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #2 clk = ~clk;   // 250 MHz

    tmr_ctrl_fsm #(.RUN_LEN(RUN_LEN)) u_dut (
        .clk(clk), .rst(rst), .start_req(start_req), .stop_req(stop_req),
        .fault_mask(fault_mask), .state_o(state_o), .busy(busy), .done(done),
        .mismatch(mismatch)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check_out(input string req, input logic [2:0] st, input logic b,
                             input logic d, input logic m);
        check({req, " state"}, state_o, st);
        check({req, " busy"}, busy, b);
        check({req, " done"}, done, d);
        check({req, " mismatch"}, mismatch, m);
    endtask

    task automatic do_reset();
        rst = 1'b1; fault_mask = 9'h1FF; start_req = 1'b1;
        tick(); tick();
        rst = 1'b0; fault_mask = '0; start_req = 1'b0;
        check_out("R1 reset", 3'b000, 0, 0, 0);
    endtask

    // Full sequence; inj_copy < 0 means no injection, else copy index hit in Run
    task automatic t_sequence(input int inj_copy);
        string tag;
        tag = (inj_copy < 0) ? "R2/R3 seq" : "R5/R9 inj";
        start_req = 1'b1; tick(); start_req = 1'b0;
        check_out({tag, " arm"}, 3'b011, 1, 0, 0);
        tick();
        check_out({tag, " run0"}, 3'b101, 1, 0, 0);
        for (int k = 1; k < RUN_LEN; k++) begin
            if (k == 1 && inj_copy >= 0) fault_mask = 9'b111 << (3 * inj_copy);
            start_req = 1'b1;   // ignored outside Idle (R4)
            tick();
            fault_mask = '0; start_req = 1'b0;
            check({tag, " R5 run"}, state_o, 3'b101);
            check({tag, " R7 mismatch"}, mismatch, (inj_copy >= 0 && k == 2));
        end
        tick();
        check_out({tag, " R3 done"}, 3'b110, 0, 1, 0);
        tick();
        check_out({tag, " R3 idle after done"}, 3'b000, 0, 0, 0);
    endtask

    task automatic t_stop();
        start_req = 1'b1; stop_req = 1'b1; tick();
        check_out("R4 stop beats start", 3'b000, 0, 0, 0);
        stop_req = 1'b0; tick(); start_req = 1'b0;
        check_out("R4 arm", 3'b011, 1, 0, 0);
        stop_req = 1'b1; tick(); stop_req = 1'b0;
        check_out("R4 stop in arm", 3'b000, 0, 0, 0);
        start_req = 1'b1; tick(); start_req = 1'b0; tick(); tick();
        check_out("R4 in run", 3'b101, 1, 0, 0);
        stop_req = 1'b1; tick(); stop_req = 1'b0;
        check_out("R4 stop in run", 3'b000, 0, 0, 0);
    endtask

    task automatic t_illegal();
        fault_mask = {3'b000, 3'b001, 3'b001}; tick(); fault_mask = '0;
        check_out("R8 illegal voted", 3'b001, 0, 0, 0);
        tick();
        check_out("R8 back to idle", 3'b000, 0, 0, 1);
        tick();
        check_out("R6 scrubbed", 3'b000, 0, 0, 0);
    endtask

    task automatic t_reset_midrun();
        start_req = 1'b1; tick(); start_req = 1'b0; tick();
        check("R1 pre-reset run", state_o, 3'b101);
        rst = 1'b1; tick(); rst = 1'b0;
        check_out("R1 reset mid run", 3'b000, 0, 0, 0);
    endtask

    initial begin
        do_reset();
        t_sequence(-1);
        t_sequence(0);
        t_sequence(1);
        t_sequence(2);
        t_stop();
        t_illegal();
        t_reset_midrun();
        t_sequence(-1);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule